// File: doc/BRIEF.md
# Two-Wire Register Access Target with Strapped Address

This block is a target-only I2C/SMBus endpoint that gives a bus host access to two 16-bit words. One is a configuration word held inside the block. The other is a measurement word supplied by the surrounding logic. SCL is only ever an input. SDA is read as an input and pulled low through an open-drain enable, with the pad and the pull-up outside the block.

A two-bit strap input picks one of three 7-bit target addresses. Every access begins with an address byte in write direction, followed by a command byte.
- A write sends two data bytes after the command, least significant byte first.
- A read issues a repeated START, then the address in read direction, then clocks out two bytes, least significant byte first.

One command code reaches the configuration word. Three measurement codes all return the same measurement word. Every other code is refused.

Both bus lines pass through a synchroniser and edge detector running on the system clock. The system clock must be at least eight times the SCL rate.

Top module: `smb_reg_slave`

## Requirements
- R1: The strap input selects the target address: 2'b00 gives 7'b1110000, 2'b01 gives 7'b1110010, 2'b10 gives 7'b1110110, and 2'b11 is treated like 2'b01. A byte whose upper seven bits differ from the selected address is not acknowledged, and SDA stays released for the rest of that transfer.
- R2: A write is START, address+W (bit 0 = 0), command 8'hD0, low byte, high byte. Each of these bytes is acknowledged, and the configuration output then holds {high, low}.
- R3: A read is START, address+W, command, repeated START, address+R (bit 0 = 1). The target then sends the low byte and then the high byte, each most significant bit first. It stops sending after the host NACKs.
- R4: Command 8'hD0 reads back the configuration word. Commands 8'h8B, 8'h8C and 8'h96 each return the measurement input.
- R5: The word being read is captured when its first byte is loaded. A change on the measurement input between the two bytes does not reach the second byte.
- R6: The configuration word changes only after both data bytes have been acknowledged. A write cut short by STOP after one byte leaves it unchanged. A third data byte is NACKed and has no effect.
- R7: Any command code other than the four above is NACKed, including the reserved codes D2h–D5h, D7h and D8h. Data bytes that follow such a code are NACKed and leave the configuration word unchanged. Data bytes written after a measurement command are also NACKed.
- R8: An address+R that does not follow an accepted command within the same transfer is NACKed.
- R9: SDA is only ever pulled low, never driven high. The pull-down is asserted only while the synchronised SCL is low, and it is released on STOP.
- R10: The protocol works for SCL high and low phases from 6 to 250 system clocks.
- R11: `cfg_wr_stb` pulses for one cycle, in the same cycle that a new configuration word appears on `cfg_o`, and `cfg_o` changes at no other time. `meas_rd_stb` pulses for one cycle for each capture of the measurement word.
- R12: After reset the configuration word is 16'h0000, SDA is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 2 | Address strap: 00 low, 01 open, 10 high |
| meas_i | input | 16 | Measurement word returned by the read codes |
| cfg_o | output | 16 | Configuration word |
| cfg_wr_stb | output | 1 | One-cycle pulse when cfg_o is updated |
| meas_rd_stb | output | 1 | One-cycle pulse when the measurement word is captured |

## Verification
The bench goes after these corner cases:
- **Byte order.** A design that swapped the bytes would read back a byte-reversed word.
- **Capture on the first byte.** A design that fetched the measurement word again for the second byte would mix the halves of two values when the input changes mid-read.
- **Partial and over-long writes.** A design that loaded each byte as it arrived would corrupt the configuration word on a write cut short by STOP, or on a third byte.
- **Reserved codes and read-only codes.** A design that failed to refuse these would acknowledge and absorb data it should ignore.
- **Address strap and bus rates.** Every strap setting is tried, a foreign address is tried, and transfers run at both a very fast and a very slow SCL. These catch address decode mistakes and edge-detection timing faults.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  localparam logic [BYTE_W-1:0] CMD_CFG  = 8'hD0;
  localparam logic [BYTE_W-1:0] CMD_VOLT = 8'h8B;
  localparam logic [BYTE_W-1:0] CMD_CURR = 8'h8C;
  localparam logic [BYTE_W-1:0] CMD_PWR  = 8'h96;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CMD, S_WR, S_ACK, S_RD, S_MACK, S_SKIP
  } smb_state_e;

  typedef enum logic [1:0] {CK_NONE, CK_CFG, CK_MEAS} cmd_kind_e;

  // Strap setting to 7-bit target address
  function automatic logic [ADDR_W-1:0] strap_addr(input logic [1:0] s);
    case (s)
      2'b00:   return 7'b1110000;
      2'b10:   return 7'b1110110;
      default: return 7'b1110010;
    endcase
  endfunction

  // Command byte classification
  function automatic cmd_kind_e decode_cmd(input logic [BYTE_W-1:0] c);
    if (c == CMD_CFG) return CK_CFG;
    if (c == CMD_VOLT || c == CMD_CURR || c == CMD_PWR) return CK_MEAS;
    return CK_NONE;
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~prev;
  assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det (
  input  logic scl_lvl_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  // SDA moving while SCL is high marks a bus condition
  assign start_o = sda_fall_i & scl_lvl_i;
  assign stop_o  = sda_rise_i & scl_lvl_i;
endmodule

// File: rtl/smb_regs.sv
module smb_regs
  import smb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              snap_i,
  input  logic              src_cfg_i,
  input  logic [WORD_W-1:0] meas_i,
  output logic [WORD_W-1:0] cfg_o,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [WORD_W-1:0] snap_o,
  output logic              cfg_stb_o,
  output logic              meas_stb_o
);
  logic [WORD_W-1:0] cfg_q, snap_q;

  assign rd_word_o = src_cfg_i ? cfg_q : meas_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      snap_q     <= '0;
      cfg_stb_o  <= 1'b0;
      meas_stb_o <= 1'b0;
    end else begin
      if (commit_i) cfg_q <= wdata_i;
      if (snap_i) snap_q <= rd_word_o;
      cfg_stb_o  <= commit_i;
      meas_stb_o <= snap_i & ~src_cfg_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign snap_o = snap_q;
endmodule

// File: rtl/smb_proto.sv
module smb_proto
  import smb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] my_addr_i,
  input  logic [WORD_W-1:0] rd_word_i,
  input  logic [WORD_W-1:0] snap_i,
  output logic              sda_oe_o,
  output logic              commit_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              snap_load_o,
  output logic              src_cfg_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  smb_state_e        st, after, nxt;
  cmd_kind_e         kind;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx, tx, lo;
  logic [1:0]        bidx;
  logic              oe, pend, mack, ok;

  // Accept/refuse decision for the byte just received
  always_comb begin
    ok  = 1'b0;
    nxt = S_SKIP;
    case (st)
      S_ADDR:
        if (rx[BYTE_W-1:1] == my_addr_i) begin
          if (!rx[0]) begin
            ok = 1'b1; nxt = S_CMD;
          end else if (kind != CK_NONE) begin
            ok = 1'b1; nxt = S_RD;
          end
        end
      S_CMD:
        if (decode_cmd(rx) != CK_NONE) begin
          ok = 1'b1; nxt = S_WR;
        end
      S_WR:
        if (kind == CK_CFG && bidx < 2'd2) begin
          ok = 1'b1; nxt = S_WR;
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; after <= S_IDLE; kind <= CK_NONE;
      cnt <= '0; rx <= '0; tx <= '0; lo <= '0; bidx <= '0;
      oe <= 1'b0; pend <= 1'b0; mack <= 1'b1;
      wdata_o <= '0; commit_o <= 1'b0; snap_load_o <= 1'b0;
    end else begin
      commit_o    <= 1'b0;
      snap_load_o <= 1'b0;
      if (start_i) begin
        st <= S_ADDR; cnt <= '0; oe <= 1'b0; pend <= 1'b0;
      end else if (stop_i) begin
        st <= S_IDLE; oe <= 1'b0; pend <= 1'b0; kind <= CK_NONE;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WR: begin
            if (scl_rise_i) begin
              rx  <= {rx[BYTE_W-2:0], sda_lvl_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == FULL) begin
              cnt <= '0;
              if (st == S_CMD) kind <= decode_cmd(rx);
              if (ok) begin
                st <= S_ACK; oe <= 1'b1; after <= nxt;
                if (st == S_ADDR) begin
                  bidx <= '0;
                  if (!rx[0]) kind <= CK_NONE;
                end
                if (st == S_WR) begin
                  if (bidx == 2'd0) lo <= rx;
                  else begin
                    wdata_o <= {rx, lo};
                    pend    <= 1'b1;
                  end
                  bidx <= bidx + 2'd1;
                end
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_ACK:
            if (scl_fall_i) begin
              st <= after; oe <= 1'b0; cnt <= '0;
              if (pend) begin
                commit_o <= 1'b1; pend <= 1'b0;
              end
              if (after == S_RD) begin
                tx          <= rd_word_i[BYTE_W-1:0];
                oe          <= ~rd_word_i[BYTE_W-1];
                snap_load_o <= 1'b1;
                bidx        <= 2'd1;
              end
            end
          S_RD:
            if (scl_fall_i) begin
              if (cnt == LAST) begin
                oe <= 1'b0; st <= S_MACK; cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1;
                tx  <= {tx[BYTE_W-2:0], 1'b0};
                oe  <= ~tx[BYTE_W-2];
              end
            end
          S_MACK:
            if (scl_rise_i) mack <= sda_lvl_i;
            else if (scl_fall_i) begin
              if (!mack && bidx == 2'd1) begin
                tx   <= snap_i[WORD_W-1:BYTE_W];
                oe   <= ~snap_i[WORD_W-1];
                bidx <= 2'd2;
                st   <= S_RD;
              end else begin
                st <= S_SKIP;
              end
            end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe;
  assign src_cfg_o = (kind == CK_CFG);
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap_i,
  input  logic [WORD_W-1:0] meas_i,
  output logic [WORD_W-1:0] cfg_o,
  output logic              cfg_wr_stb,
  output logic              meas_rd_stb
);
  localparam int LINES = 2;  // index 0 = SCL, 1 = SDA

  logic [LINES-1:0] raw, lvl, rse, fll;
  logic             scl_lvl, start_ev, stop_ev;
  logic             commit, snap_load, src_cfg;
  logic [WORD_W-1:0] wdata, rd_word, snap_q;
  logic [ADDR_W-1:0] my_addr;

  assign raw     = {sda_i, scl_i};
  assign scl_lvl = lvl[0];
  assign my_addr = strap_addr(strap_i);

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_i(raw[g]),
      .level_o(lvl[g]), .rise_o(rse[g]), .fall_o(fll[g])
    );
  end

  smb_cond_det u_cond (
    .scl_lvl_i(scl_lvl), .sda_rise_i(rse[1]), .sda_fall_i(fll[1]),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  smb_proto u_proto (
    .clk(clk), .rst_n(rst_n),
    .scl_rise_i(rse[0]), .scl_fall_i(fll[0]), .sda_lvl_i(lvl[1]),
    .start_i(start_ev), .stop_i(stop_ev), .my_addr_i(my_addr),
    .rd_word_i(rd_word), .snap_i(snap_q),
    .sda_oe_o(sda_oe), .commit_o(commit), .wdata_o(wdata),
    .snap_load_o(snap_load), .src_cfg_o(src_cfg)
  );

  smb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .wdata_i(wdata),
    .snap_i(snap_load), .src_cfg_i(src_cfg), .meas_i(meas_i),
    .cfg_o(cfg_o), .rd_word_o(rd_word), .snap_o(snap_q),
    .cfg_stb_o(cfg_wr_stb), .meas_stb_o(meas_rd_stb)
  );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_lvl,
  input logic        stop_ev,
  input logic        sda_oe,
  input logic [15:0] cfg_o,
  input logic        cfg_wr_stb,
  input logic        meas_rd_stb,
  input logic        snap_load,
  input logic [15:0] snap_q
);
  // R11: configuration moves only together with its strobe
  a_r11_cfg_moves_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o != $past(cfg_o)) |-> cfg_wr_stb);

  // R11: strobes are single-cycle pulses
  a_r11_cfg_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_stb |=> !cfg_wr_stb);
  a_r11_meas_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    meas_rd_stb |=> !meas_rd_stb);

  // R5: captured word changes only after a load request
  a_r5_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_q != $past(snap_q)) |-> $past(snap_load));

  // R9: pull-down only starts while SCL is low
  a_r9_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_lvl));

  // R9: STOP releases the line
  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
endmodule

bind smb_reg_slave smb_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .stop_ev(stop_ev),
  .sda_oe(sda_oe), .cfg_o(cfg_o), .cfg_wr_stb(cfg_wr_stb),
  .meas_rd_stb(meas_rd_stb), .snap_load(snap_load), .snap_q(snap_q)
);

// File: tb/sim_smb_reg_slave.sv
`timescale 1ns/1ps
module sim_smb_reg_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0]  strap = 2'b00;
  logic [15:0] meas = 16'h0000;
  logic        sda_oe, cfg_wr_stb, meas_rd_stb;
  logic [15:0] cfg_o;
  wire         sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  smb_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(strap), .meas_i(meas), .cfg_o(cfg_o),
    .cfg_wr_stb(cfg_wr_stb), .meas_rd_stb(meas_rd_stb)
  );

  int n_cmp = 0, n_bad = 0, hp = 20;
  int cnt_cfg = 0, cnt_meas = 0, exp_commits = 0, exp_meas = 0;
  bit mon_on = 0, may_drive = 1, alt_ok = 0, done = 0;
  logic [15:0] exp_cfg = 16'h0000, alt_cfg = 16'h0000;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      n_cmp++;
      if (!(cfg_o == exp_cfg || (alt_ok && cfg_o == alt_cfg))) begin
        n_bad++;
        $display("FAIL R6 cfg_o act=%0h exp=%0h", cfg_o, exp_cfg);
      end
      if (sda_oe && !may_drive) begin
        n_bad++;
        $display("FAIL R1 sda_oe act=1 exp=0");
      end
      if (cfg_wr_stb) cnt_cfg++;
      if (meas_rd_stb) cnt_meas++;
    end
  end

  function automatic logic [6:0] exp_addr(input logic [1:0] s);
    if (s == 2'b00) return 7'h70;
    if (s == 2'b10) return 7'h76;
    return 7'h72;
  endfunction

  task automatic bit_out(input logic b);
    tick(hp / 2); sda_m = b; tick(hp - hp / 2); scl_m = 1'b1; tick(hp); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    tick(hp / 2); sda_m = 1'b1; tick(hp - hp / 2); scl_m = 1'b1;
    tick(hp / 2); b = sda_line; tick(hp - hp / 2); scl_m = 1'b0;
  endtask

  task automatic byte_out(input logic [7:0] d, output logic ak);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(x);
    ak = !x;
  endtask

  task automatic byte_in(output logic [7:0] d, input logic ack_m);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(!ack_m);
  endtask

  task automatic do_start;
    if (scl_m) tick(hp);
    else begin
      tick(hp / 2); sda_m = 1'b1; tick(hp - hp / 2); scl_m = 1'b1; tick(hp);
    end
    sda_m = 1'b0; tick(hp); scl_m = 1'b0;
  endtask

  task automatic do_stop;
    tick(hp / 2); sda_m = 1'b0; tick(hp - hp / 2); scl_m = 1'b1; tick(hp);
    sda_m = 1'b1; tick(hp);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] cmd, input int n,
                        input logic [23:0] dat, output logic aa, output logic ac,
                        output logic [2:0] ad);
    do_start;
    byte_out({a, 1'b0}, aa);
    byte_out(cmd, ac);
    ad = '0;
    for (int i = 0; i < n; i++) byte_out(dat[8*i +: 8], ad[i]);
    do_stop;
    tick(4);
  endtask

  task automatic rd_txn(input logic [6:0] a, input logic [7:0] cmd, input bit poke,
                        output logic aa, output logic ac, output logic ar,
                        output logic [15:0] w);
    logic [7:0] lo, hi;
    do_start;
    byte_out({a, 1'b0}, aa);
    byte_out(cmd, ac);
    do_start;
    byte_out({a, 1'b1}, ar);
    w = 16'hFFFF;
    if (ar) begin
      byte_in(lo, 1'b1);
      if (poke) meas = ~meas;
      byte_in(hi, 1'b0);
      w = {hi, lo};
    end
    do_stop;
    tick(4);
  endtask

  // Complete configuration write with model update
  task automatic cfg_write(input string tag, input logic [15:0] v);
    logic aa, ac;
    logic [2:0] ad;
    alt_cfg = v; alt_ok = 1;
    wr_txn(exp_addr(strap), 8'hD0, 2, {8'h00, v}, aa, ac, ad);
    exp_cfg = v; alt_ok = 0; exp_commits++;
    chk({tag, " acks"}, {aa, ac, ad[1:0]}, 4'b1111);
    chk({tag, " cfg_o"}, cfg_o, v);
  endtask

  task automatic rd_check(input string tag, input logic [7:0] cmd, input logic [15:0] expw);
    logic aa, ac, ar;
    logic [15:0] w;
    rd_txn(exp_addr(strap), cmd, 1'b0, aa, ac, ar, w);
    chk({tag, " acks"}, {aa, ac, ar}, 3'b111);
    chk({tag, " word"}, w, expw);
  endtask

  initial begin
    tick(190000);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    report();
  end

  initial begin
    logic aa, ac, ar;
    logic [2:0] ad;
    logic [15:0] w;
    logic [7:0] rsv [7];
    rsv = '{8'hD2, 8'hD3, 8'hD4, 8'hD5, 8'hD7, 8'hD8, 8'h00};

    tick(10);
    // R12: reset state
    chk("R12 cfg_o", cfg_o, 16'h0000);
    chk("R12 sda_oe", sda_oe, 0);
    chk("R12 strobes", {cfg_wr_stb, meas_rd_stb}, 2'b00);
    rst_n = 1'b1;
    tick(5);
    mon_on = 1;

    // R1: foreign address is ignored
    may_drive = 0;
    wr_txn(7'h72, 8'hD0, 2, 24'h00_9999, aa, ac, ad);
    chk("R1 foreign addr ack", aa, 0);
    chk("R1 foreign cfg", cfg_o, 16'h0000);
    may_drive = 1;

    // R1: each strap setting
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      tick(4);
      cfg_write("R1 strap", {8'h5A + 8'(s), 8'hC3 ^ 8'(s)});
    end

    // R2/R3: byte order for write and read
    cfg_write("R2 write", 16'h1234);
    rd_check("R3 cfg read", 8'hD0, 16'h1234);

    // R4: three measurement codes, one word
    meas = 16'hBEEF;
    rd_check("R4 code 8B", 8'h8B, 16'hBEEF);
    rd_check("R4 code 8C", 8'h8C, 16'hBEEF);
    rd_check("R4 code 96", 8'h96, 16'hBEEF);
    exp_meas += 3;

    // R5: input changes between the two bytes
    meas = 16'h1357;
    rd_txn(exp_addr(strap), 8'h96, 1'b1, aa, ac, ar, w);
    exp_meas++;
    chk("R5 snapshot word", w, 16'h1357);

    // R7: reserved and unknown codes
    foreach (rsv[i]) begin
      wr_txn(exp_addr(strap), rsv[i], 2, 24'h00_A5A5, aa, ac, ad);
      chk("R7 reserved code nack", {aa, ac, ad[1:0]}, 4'b1000);
    end
    chk("R7 cfg after reserved", cfg_o, 16'h1234);
    wr_txn(exp_addr(strap), 8'h8B, 2, 24'h00_7777, aa, ac, ad);
    chk("R7 data after read code", {aa, ac, ad[1:0]}, 4'b1100);

    // R6: write cut short, and an extra byte
    wr_txn(exp_addr(strap), 8'hD0, 1, 24'h0000_EE, aa, ac, ad);
    chk("R6 partial acks", {aa, ac, ad[0]}, 3'b111);
    chk("R6 partial cfg", cfg_o, 16'h1234);
    alt_cfg = 16'hBBAA; alt_ok = 1;
    wr_txn(exp_addr(strap), 8'hD0, 3, 24'hCC_BB_AA, aa, ac, ad);
    exp_cfg = 16'hBBAA; alt_ok = 0; exp_commits++;
    chk("R6 third byte nack", ad, 3'b011);
    chk("R6 cfg after 3 bytes", cfg_o, 16'hBBAA);

    // R8: read address with no command
    do_start;
    byte_out({exp_addr(strap), 1'b1}, ar);
    do_stop;
    tick(4);
    chk("R8 bare read nack", ar, 0);

    // R10: fast and slow SCL
    hp = 6;
    cfg_write("R10 fast", 16'h0F0F);
    rd_check("R10 fast read", 8'hD0, 16'h0F0F);
    hp = 250;
    cfg_write("R10 slow", 16'hF00F);
    rd_check("R10 slow read", 8'hD0, 16'hF00F);
    hp = 20;

    // R11: strobe counts
    tick(10);
    chk("R11 cfg strobes", cnt_cfg, exp_commits);
    chk("R11 meas strobes", cnt_meas, exp_meas);
    chk("R9 line released", sda_oe, 0);

    report();
  end
endmodule